// File: doc/BRIEF.md
# Sink-side framing rule checker for a 16-bit packet-over-link word stream

This block watches the decoded word stream of a packet interface receiver, one word per clock, and raises an error strobe whenever the stream breaks a framing rule that does not belong to any single packet. Each word arrives with four side flags:
- a control/data flag;
- a parity-error flag produced by an upstream checker;
- a flag that marks a training sequence in progress;
- an in-frame flag from the receiver's alignment logic.

The checker applies six independent rules. Each rule has its own bit in an 8-bit status vector. The status vector and a shared error strobe appear together, one clock after the offending word is sampled. Downstream logic can count or log the errors from these outputs.

A control word is laid out as follows:
- bit 15 is the type: 1 means a payload control word, 0 means any other control word.
- bits 14:13 carry the end-of-packet status. 00 means no end of packet.
- bit 12 marks the start of a packet.
- bits 11:4 hold the channel address.
- bits 3:0 hold the parity nibble. The checker ignores it.

The following non-payload control words have names in the rules below:
- An idle control word has bits 14:4 all zero.
- A training control word has bits 14:12 zero and bits 11:4 all ones.

While the link is out of frame, every rule is silent and all history is dropped.

Top module: `spi4_sink_err_chk`

## Requirements
- R1: Status bit 0 is set for an in-frame payload control word with bit 12 set when the previous such start word seen in frame came fewer than MIN_SOP_GAP (default 8) cycles earlier. A distance of exactly MIN_SOP_GAP is legal. Every start word restarts the distance, and there is no prior start word after reset or after an out-of-frame cycle.
- R2: Status bit 1 is set for an in-frame control word whose bits 14:13 are not 00 when the previous in-frame word was not a data word. This includes the first word after reset or after an out-of-frame cycle.
- R3: Status bit 2 is set for an in-frame control word when the previous in-frame word was a payload control word.
- R4: Status bit 3 is set when the parity-error flag is high on an in-frame word and either the training flag is high or the word is an idle or training control word.
- R5: Status bit 4 is set for an in-frame non-payload control word with bit 12 set.
- R6: Status bit 5 is set for an in-frame non-payload control word whose bits 11:4 are not zero, unless it is a training control word. Payload control words never set it.
- R7: Status bits 7:6 are always 0. The error strobe is high in exactly the cycles in which at least one status bit is high. Several rule bits may be set together.
- R8: A word sampled at a rising edge shows its status right after that edge, for one cycle only. The next word's result replaces it.
- R9: A word sampled with the in-frame flag low produces an all-zero status. It also clears the start-spacing history and the previous-word history.
- R10: While reset is asserted, and after reset until the first in-frame word, the strobe and status are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| rx_word | input | 16 | Received word |
| rx_ctrl | input | 1 | High when rx_word is a control word |
| rx_dip_err | input | 1 | Upstream parity check failed for this word |
| rx_training | input | 1 | Training sequence in progress |
| rx_in_frame | input | 1 | Receiver is aligned to the stream |
| bus_err | output | 1 | Error strobe, high when any status bit is high |
| err_stat | output | 8 | Per-rule error bits, bits 7:6 always 0 |

## Verification
The bench probes start-word spacing at distances 2, 7 and exactly 8:
- A checker with an off-by-one compare would flag the legal distance of 8 or miss the distance of 7.
- A checker that only restarts the distance on clean start words would miss a second close start word that follows a violating one.

Several cases depend on history being cleared when the link leaves frame:
- A start word just before a loss of frame, followed by another just after it.
- A payload control word followed by a frame drop.

A checker that forgets to clear its history would report false spacing or payload-follow errors in these cases.

The remaining cases separate similar-looking words:
- A training control word must not trip the address rule.
- A parity error on a data word outside training must stay silent.
- A word that breaks several rules must light every matching bit in one and the same cycle.

// File: rtl/spi4_chk_pkg.sv
package spi4_chk_pkg;

   localparam int STAT_W = 8;

   localparam int ST_SOP_GAP    = 0;
   localparam int ST_EOP_NODATA = 1;
   localparam int ST_PAY_NODATA = 2;
   localparam int ST_DIP_IDLE   = 3;
   localparam int ST_RSVD       = 4;
   localparam int ST_ADDR_NZ    = 5;
   localparam int ST_USED       = 6;

   typedef struct packed {
      logic pay;       // payload control word
      logic sop;       // payload control word opening a packet
      logic eop;       // control word closing a packet
      logic npc;       // non-payload control word
      logic idle;      // idle control word
      logic train_cw;  // training control word
      logic rsvd;      // reserved encoding
      logic addr_nz;   // non-payload control word with address bits set
   } cw_info_t;

endpackage

// File: rtl/spi4_cw_decode.sv
module spi4_cw_decode
   import spi4_chk_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DIP_W  = 4
) (
   input  logic [3+ADDR_W+DIP_W:0] word,
   input  logic                    is_ctrl,
   output cw_info_t                info
);

   localparam int WORD_W  = 4 + ADDR_W + DIP_W;
   localparam int TYPE_B  = WORD_W - 1;
   localparam int EOPS_HI = WORD_W - 2;
   localparam int EOPS_LO = WORD_W - 3;
   localparam int SOP_B   = WORD_W - 4;
   localparam int ADDR_HI = SOP_B - 1;
   localparam int ADDR_LO = DIP_W;

   logic [ADDR_W-1:0] addr;
   logic [1:0]        eops;
   logic              quiet_hdr;
   logic              unused_dip;

   assign addr       = word[ADDR_HI:ADDR_LO];
   assign eops       = word[EOPS_HI:EOPS_LO];
   assign unused_dip = ^word[DIP_W-1:0];
   assign quiet_hdr  = (eops == 2'b00) && !word[SOP_B];

   always_comb begin
      info          = '0;
      info.pay      = is_ctrl &  word[TYPE_B];
      info.npc      = is_ctrl & ~word[TYPE_B];
      info.sop      = info.pay & word[SOP_B];
      info.eop      = is_ctrl & (eops != 2'b00);
      info.rsvd     = info.npc & word[SOP_B];
      info.train_cw = info.npc & quiet_hdr & (&addr);
      info.idle     = info.npc & quiet_hdr & (addr == '0);
      info.addr_nz  = info.npc & (addr != '0);
   end

endmodule

// File: rtl/spi4_sop_gap.sv
module spi4_sop_gap #(
   parameter int MIN_SOP_GAP = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_frame,
   input  logic sop,
   output logic viol
);

   localparam int CNT_W = $clog2(MIN_SOP_GAP + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_SOP_GAP);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] dist_q;

   assign viol = in_frame && sop && (dist_q < CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dist_q <= CNT_MAX;
      end else if (!in_frame) begin
         dist_q <= CNT_MAX;
      end else if (sop) begin
         dist_q <= CNT_ONE;
      end else if (dist_q != CNT_MAX) begin
         dist_q <= dist_q + CNT_ONE;
      end
   end

   a_r1_dist_bound: assert property (@(posedge clk) disable iff (!rst_n)
      dist_q <= CNT_MAX);

   a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && sop) |=> (dist_q == CNT_ONE));

   a_r9_gap_forget: assert property (@(posedge clk) disable iff (!rst_n)
      !in_frame |=> (dist_q == CNT_MAX));

endmodule

// File: rtl/spi4_seq_hist.sv
module spi4_seq_hist (
   input  logic clk,
   input  logic rst_n,
   input  logic in_frame,
   input  logic is_ctrl,
   input  logic is_pay,
   output logic prev_data,
   output logic prev_pay
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_data <= 1'b0;
         prev_pay  <= 1'b0;
      end else if (!in_frame) begin
         prev_data <= 1'b0;
         prev_pay  <= 1'b0;
      end else begin
         prev_data <= !is_ctrl;
         prev_pay  <= is_pay;
      end
   end

   a_r9_hist_forget: assert property (@(posedge clk) disable iff (!rst_n)
      !in_frame |=> (!prev_data && !prev_pay));

   a_r3_pay_tracked: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && is_pay) |=> prev_pay);

   a_r2_data_tracked: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && !is_ctrl) |=> prev_data);

endmodule

// File: rtl/spi4_sink_err_chk.sv
module spi4_sink_err_chk
   import spi4_chk_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DIP_W       = 4,
   parameter int MIN_SOP_GAP = 8,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [3+ADDR_W+DIP_W:0] rx_word,
   input  logic                    rx_ctrl,
   input  logic                    rx_dip_err,
   input  logic                    rx_training,
   input  logic                    rx_in_frame,
   output logic                    bus_err,
   output logic [STAT_W-1:0]       err_stat
);

   if (MIN_SOP_GAP < 2) begin : g_bad_gap
      $error("MIN_SOP_GAP must be at least 2");
   end
   if (ADDR_W < 1 || DIP_W < 1) begin : g_bad_fields
      $error("address and parity fields must be at least one bit wide");
   end

   cw_info_t          info;
   logic              gap_viol;
   logic              prev_data;
   logic              prev_pay;
   logic [STAT_W-1:0] stat_nxt;

   spi4_cw_decode #(
      .ADDR_W (ADDR_W),
      .DIP_W  (DIP_W)
   ) u_decode (
      .word    (rx_word),
      .is_ctrl (rx_ctrl),
      .info    (info)
   );

   spi4_sop_gap #(
      .MIN_SOP_GAP (MIN_SOP_GAP)
   ) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_frame (rx_in_frame),
      .sop      (info.sop),
      .viol     (gap_viol)
   );

   spi4_seq_hist u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_frame  (rx_in_frame),
      .is_ctrl   (rx_ctrl),
      .is_pay    (info.pay),
      .prev_data (prev_data),
      .prev_pay  (prev_pay)
   );

   always_comb begin
      stat_nxt = '0;
      if (rx_in_frame) begin
         stat_nxt[ST_SOP_GAP]    = gap_viol;
         stat_nxt[ST_EOP_NODATA] = info.eop & ~prev_data;
         stat_nxt[ST_PAY_NODATA] = rx_ctrl & prev_pay;
         stat_nxt[ST_DIP_IDLE]   = rx_dip_err & (rx_training | info.idle | info.train_cw);
         stat_nxt[ST_RSVD]       = info.rsvd;
         stat_nxt[ST_ADDR_NZ]    = info.addr_nz & ~info.train_cw;
      end
   end

   if (OUT_REG) begin : g_reg_out
      logic [STAT_W-1:0] stat_q;
      logic              strobe_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stat_q   <= '0;
            strobe_q <= 1'b0;
         end else begin
            stat_q   <= stat_nxt;
            strobe_q <= |stat_nxt[ST_USED-1:0];
         end
      end

      assign err_stat = stat_q;
      assign bus_err  = strobe_q;

      a_r9_oof_silent: assert property (@(posedge clk) disable iff (!rst_n)
         !rx_in_frame |=> (err_stat == '0));

      a_r5_rsvd_flagged: assert property (@(posedge clk) disable iff (!rst_n)
         (rx_in_frame && rx_ctrl && !rx_word[3+ADDR_W+DIP_W] && rx_word[ADDR_W+DIP_W])
         |=> (err_stat[ST_RSVD] && bus_err));
   end else begin : g_comb_out
      assign err_stat = stat_nxt;
      assign bus_err  = |stat_nxt[ST_USED-1:0];
   end

   a_r7_strobe_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (err_stat != '0));

   a_r7_cause_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (err_stat != '0) |-> bus_err);

endmodule

// File: tb/spi4_sink_err_chk_bench.sv
`timescale 1ns/1ps
module spi4_sink_err_chk_bench;

   localparam int GAP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] rx_word = '0;
   logic        rx_ctrl = 1'b0;
   logic        rx_dip_err = 1'b0;
   logic        rx_training = 1'b0;
   logic        rx_in_frame = 1'b0;
   logic        bus_err;
   logic [7:0]  err_stat;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   int m_since = 1000;
   bit m_pd    = 1'b0;
   bit m_pp    = 1'b0;

   always #2 clk = ~clk;

   spi4_sink_err_chk u_spi4_sink_err_chk (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_word     (rx_word),
      .rx_ctrl     (rx_ctrl),
      .rx_dip_err  (rx_dip_err),
      .rx_training (rx_training),
      .rx_in_frame (rx_in_frame),
      .bus_err     (bus_err),
      .err_stat    (err_stat)
   );

   function automatic logic [15:0] cw(input bit pay, input logic [1:0] eops,
                                      input bit sop, input logic [7:0] addr);
      return {pay, eops, sop, addr, 4'h0};
   endfunction

   // Drive one word and queue the status the requirements predict for it.
   task automatic send(input logic [15:0] w, input bit c, input bit d,
                       input bit t, input bit f, input string tag);
      logic [7:0] e;
      bit pay, sop, npc, trw, idl;
      e   = '0;
      pay = c && w[15];
      sop = pay && w[12];
      npc = c && !w[15];
      trw = npc && (w[14:4] == 11'h0FF);
      idl = npc && (w[14:4] == 11'h000);
      if (!f) begin
         m_since = 1000; m_pd = 1'b0; m_pp = 1'b0;
      end else begin
         e[0] = sop && (m_since < GAP);                // R1
         e[1] = c && (w[14:13] != 2'b00) && !m_pd;     // R2
         e[2] = c && m_pp;                             // R3
         e[3] = d && (t || idl || trw);                // R4
         e[4] = npc && w[12];                          // R5
         e[5] = npc && (w[11:4] != 8'h00) && !trw;     // R6
         m_since = sop ? 1 : m_since + 1;
         m_pd = !c;
         m_pp = pay;
      end
      @(negedge clk);
      #1;
      rx_word = w; rx_ctrl = c; rx_dip_err = d; rx_training = t; rx_in_frame = f;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic dat(input string tag);
      send(16'hA5C3, 1'b0, 1'b0, 1'b0, 1'b1, tag);
   endtask

   task automatic idle_n(input int n, input string tag);
      for (int i = 0; i < n; i++) send(cw(0, 2'b00, 0, 8'h00), 1'b1, 1'b0, 1'b0, 1'b1, tag);
   endtask

   // Monitor: one queued item per cycle, compared after the edge that
   // registered it (R8 latency) together with the strobe rule (R7).
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [7:0] e;
         string      tg;
         e  = exp_q.pop_front();
         tg = tag_q.pop_front();
         n_cmp++;
         if (err_stat !== e || bus_err !== (e != 8'h00)) begin
            n_bad++;
            $display("FAIL %s (R8/R7 timing+strobe): stat=%08b strobe=%b expected stat=%08b strobe=%b",
                     tg, err_stat, bus_err, e, (e != 8'h00));
         end
      end
   end

   task automatic check_idle_out(input string tag);
      n_cmp++;
      if (err_stat !== 8'h00 || bus_err !== 1'b0) begin
         n_bad++;
         $display("FAIL %s: stat=%08b strobe=%b expected stat=00000000 strobe=0", tag, err_stat, bus_err);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check_idle_out("R10 during reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle_out("R10 after reset");

      // Clean packet flow, start words exactly GAP apart.
      send(cw(1, 2'b00, 1, 8'h05), 1'b1, 1'b0, 1'b0, 1'b1, "R1 clean first start");
      for (int i = 0; i < 7; i++) dat("R8 clean data");
      send(cw(1, 2'b10, 1, 8'h06), 1'b1, 1'b0, 1'b0, 1'b1, "R1 distance equal to gap");
      for (int i = 0; i < 7; i++) dat("R8 clean data");
      send(cw(0, 2'b10, 0, 8'h00), 1'b1, 1'b0, 1'b0, 1'b1, "R2 eop after data ok");
      idle_n(2, "R8 idles");

      // Spacing violations at 2 and 7, then a chained close start.
      send(cw(1, 2'b00, 1, 8'h01), 1'b1, 1'b0, 1'b0, 1'b1, "R1 start");
      dat("R1 data");
      send(cw(1, 2'b01, 1, 8'h02), 1'b1, 1'b0, 1'b0, 1'b1, "R1 distance 2");
      for (int i = 0; i < 6; i++) dat("R1 data");
      send(cw(1, 2'b01, 1, 8'h03), 1'b1, 1'b0, 1'b0, 1'b1, "R1 distance 7");
      dat("R1 data");
      send(cw(1, 2'b01, 1, 8'h03), 1'b1, 1'b0, 1'b0, 1'b1, "R1 restart after violation");
      dat("R1 data");
      idle_n(1, "R8 idle");

      // End-of-packet without data before it.
      idle_n(1, "R2 idle");
      send(cw(0, 2'b11, 0, 8'h00), 1'b1, 1'b0, 1'b0, 1'b1, "R2 eop after idle");

      // Payload control word followed by control words.
      send(cw(1, 2'b00, 1, 8'h09), 1'b1, 1'b0, 1'b0, 1'b1, "R3 payload word");
      idle_n(1, "R3 idle after payload");
      send(cw(1, 2'b00, 0, 8'h09), 1'b1, 1'b0, 1'b0, 1'b1, "R3 payload again");
      send(cw(1, 2'b10, 0, 8'h09), 1'b1, 1'b0, 1'b0, 1'b1, "R3 R2 payload after payload");
      dat("R3 data");

      // Parity flag on idle, during training, on data outside training.
      send(cw(0, 2'b00, 0, 8'h00) | 16'h0007, 1'b1, 1'b1, 1'b0, 1'b1, "R4 parity on idle");
      dat("R4 data");
      dat("R4 parity on data ignored");
      send(16'hA5C3, 1'b0, 1'b1, 1'b0, 1'b1, "R4 parity on data outside training");
      send(cw(0, 2'b00, 0, 8'hFF), 1'b1, 1'b1, 1'b1, 1'b1, "R4 R6 training cw with parity");
      send(16'h0FFF, 1'b0, 1'b1, 1'b1, 1'b1, "R4 training data with parity");
      send(cw(0, 2'b00, 0, 8'hFF), 1'b1, 1'b0, 1'b1, 1'b1, "R6 training cw exempt");

      // Reserved and address rules.
      send(cw(0, 2'b00, 1, 8'h00), 1'b1, 1'b0, 1'b0, 1'b1, "R5 reserved");
      send(cw(0, 2'b00, 0, 8'h50), 1'b1, 1'b0, 1'b0, 1'b1, "R6 idle with address");
      send(cw(0, 2'b01, 1, 8'h3C), 1'b1, 1'b1, 1'b0, 1'b1, "R7 multi-rule word");
      dat("R7 data");
      send(cw(1, 2'b00, 0, 8'h77), 1'b1, 1'b0, 1'b0, 1'b1, "R6 payload address exempt");
      dat("R6 data");

      // Out of frame: silence and history cleared.
      send(cw(1, 2'b00, 1, 8'h04), 1'b1, 1'b0, 1'b0, 1'b1, "R9 start before drop");
      send(cw(0, 2'b11, 1, 8'h44), 1'b1, 1'b1, 1'b1, 1'b0, "R9 bad word out of frame");
      send(cw(1, 2'b00, 1, 8'h04), 1'b1, 1'b0, 1'b0, 1'b1, "R9 start after drop");
      send(cw(1, 2'b00, 0, 8'h04), 1'b1, 1'b0, 1'b0, 0, "R9 drop after payload");
      send(cw(0, 2'b00, 0, 8'h00), 1'b1, 1'b0, 1'b0, 1'b1, "R9 idle after drop");
      send(cw(0, 2'b00, 0, 8'h00), 1'b1, 1'b0, 1'b0, 1'b0, "R9 leave frame");
      send(cw(0, 2'b10, 0, 8'h00), 1'b1, 1'b0, 1'b0, 1'b1, "R2 eop first after drop");
      idle_n(3, "R8 tail");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule